// File: doc/BRIEF.md
# SCL Stretch Guard

This block watches the serial clock line of a two-wire bus and raises a flag when the clock stays low for too long while a transfer is in progress. A master or a slave that stretches the clock well past what the bus allows is caught this way, and the interrupt request lets firmware step in. The raw clock pin passes through a two-flop synchronizer. A saturating counter then measures how long the synchronized clock has been low.

A two-bit select input turns detection off or picks one of three limits. Each limit is a parameter counted in system clock cycles. By default the limits are 28, 31 and 34 ms at the configured clock rate. The flag fires at most once per low period and stays set until a one-cycle clear strobe arrives. The interrupt output is the flag gated by a local enable and a global enable.

Top module: `scl_stretch_guard`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `tmo_flag` and `tmo_irq` are 0.
- R2: With `tmo_sel` = 0, `tmo_flag` never sets, however long the clock stays low.
- R3: With `tmo_sel` = 1, 2 or 3, the limit is `LIM1_CYC`, `LIM2_CYC` or `LIM3_CYC` respectively. If `scl_i` goes low and stays low, `tmo_flag` is 1 after exactly limit+3 rising clock edges and 0 after limit+2 edges.
- R4: While `xfer_busy` is 0 the low-time count is held at zero, so `tmo_flag` does not set.
- R5: After the flag is cleared during a low period, it does not set again in that same low period, even across several multiples of the limit.
- R6: Detection re-arms once the synchronized clock has been seen high. A following low period that lasts long enough sets the flag again.
- R7: `tmo_flag` stays at 1 until `tmo_clr` is sampled high. It reads 0 on the cycle after the clear, unless a new timeout fires in the same cycle, in which case the set wins.
- R8: `tmo_irq` is 1 exactly when `tmo_flag`, `tmo_ie` and `glob_ie` are all 1.
- R9: A high level on `scl_i` that lasts one clock cycle or longer restarts the measurement. The timeout is counted from the last falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Raw serial clock pin level |
| xfer_busy | input | 1 | High while the engine is sending or receiving |
| tmo_sel | input | 2 | 0 turns detection off; 1 to 3 select a limit |
| tmo_ie | input | 1 | Local interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| tmo_clr | input | 1 | One-cycle strobe that clears the flag |
| tmo_flag | output | 1 | Sticky timeout flag |
| tmo_irq | output | 1 | Interrupt request |

## Verification
A falling edge on `scl_i` takes two edges to cross the synchronizer and `limit` more edges to fill the counter. The flag register then takes one more edge, so the flag is due on the limit+3rd rising edge. The bench counts rising edges from the cycle in which it lowers the pin and samples on the falling edge that follows. For each limit it checks one edge early, where the flag must still be 0, and then the exact edge. A clear is checked on the next falling edge. `tmo_irq` has no register on its path and is checked in the same sample as the flag.

// File: rtl/sclg_pkg.sv
package sclg_pkg;

    typedef struct packed {
        logic flag;
        logic armed;
    } guard_state_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/sclg_sync.sv
module sclg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '1;
        else     pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sclg_lowcnt.sv
module sclg_lowcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_low,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             reached
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!line_low || !run) begin
            cnt_d = '0;
        end else if (cnt_q < limit) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign reached = run && line_low && (cnt_q >= limit);
endmodule

// File: rtl/scl_stretch_guard.sv
module scl_stretch_guard #(
    parameter int unsigned CLK_HZ   = 125_000_000,
    parameter int unsigned LIM1_CYC = (CLK_HZ / 1000) * 28,
    parameter int unsigned LIM2_CYC = (CLK_HZ / 1000) * 31,
    parameter int unsigned LIM3_CYC = (CLK_HZ / 1000) * 34,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       xfer_busy,
    input  logic [1:0] tmo_sel,
    input  logic       tmo_ie,
    input  logic       glob_ie,
    input  logic       tmo_clr,
    output logic       tmo_flag,
    output logic       tmo_irq
);
    import sclg_pkg::*;

    localparam int unsigned MAX_LIM = max3(LIM1_CYC, LIM2_CYC, LIM3_CYC);
    localparam int          CNT_W   = $clog2(MAX_LIM + 1);
    localparam int          N_LIM   = 3;

    logic [CNT_W-1:0] lim_tab [N_LIM];

    generate
        for (genvar g = 0; g < N_LIM; g++) begin : g_lim
            localparam int unsigned VAL = (g == 0) ? LIM1_CYC :
                                          (g == 1) ? LIM2_CYC : LIM3_CYC;
            assign lim_tab[g] = CNT_W'(VAL);
        end
    endgenerate

    logic             scl_s;
    logic             run;
    logic [CNT_W-1:0] limit;
    logic             reached;
    logic             fire;
    guard_state_t     st_d, st_q;

    sclg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (scl_i),
        .q_o (scl_s)
    );

    always_comb begin
        run   = xfer_busy && (tmo_sel != 2'd0);
        limit = (tmo_sel == 2'd0) ? lim_tab[0] : lim_tab[tmo_sel - 2'd1];
    end

    sclg_lowcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .line_low (!scl_s),
        .run      (run),
        .limit    (limit),
        .reached  (reached)
    );

    always_comb begin
        st_d = st_q;
        fire = st_q.armed && reached;
        if (scl_s) begin
            st_d.armed = 1'b1;
        end
        if (fire) begin
            st_d.flag  = 1'b1;
            st_d.armed = 1'b0;
        end else if (tmo_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.flag  <= 1'b0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tmo_flag = st_q.flag;
    assign tmo_irq  = st_q.flag & tmo_ie & glob_ie;
endmodule

// File: rtl/scl_stretch_guard_chk.sv
module scl_stretch_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       xfer_busy,
    input logic [1:0] tmo_sel,
    input logic       tmo_ie,
    input logic       glob_ie,
    input logic       tmo_clr,
    input logic       tmo_flag,
    input logic       tmo_irq
);
    // R1: reset leaves the flag low on the following cycle
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> !tmo_flag);

    // R2: detection off means no new flag
    a_r2_off_no_set: assert property (@(posedge clk) disable iff (rst)
        (!tmo_flag && tmo_sel == 2'd0) |=> !tmo_flag);

    // R4: no rise of the flag when the engine is idle
    a_r4_idle_no_set: assert property (@(posedge clk) disable iff (rst)
        (!tmo_flag && !xfer_busy) |=> !tmo_flag);

    // R7: the flag is sticky without a clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (tmo_flag && !tmo_clr) |=> tmo_flag);

    // R7: a clear with detection off always drops the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        (tmo_clr && tmo_sel == 2'd0) |=> !tmo_flag);

    // R8: a request needs the flag and both enables
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
        tmo_irq |-> (tmo_flag && tmo_ie && glob_ie));
endmodule

bind scl_stretch_guard scl_stretch_guard_chk u_guard_chk (
    .clk       (clk),
    .rst       (rst),
    .xfer_busy (xfer_busy),
    .tmo_sel   (tmo_sel),
    .tmo_ie    (tmo_ie),
    .glob_ie   (glob_ie),
    .tmo_clr   (tmo_clr),
    .tmo_flag  (tmo_flag),
    .tmo_irq   (tmo_irq)
);

// File: tb/scl_stretch_guard_tb.sv
module scl_stretch_guard_tb;
    localparam int L1 = 10;
    localparam int L2 = 20;
    localparam int L3 = 30;
    localparam int NV = 8;
    // {sel[1:0], busy, expect, low_edges[7:0]}
    localparam logic [11:0] VEC [NV] = '{
        {2'd1, 1'b1, 1'b0, 8'd12},
        {2'd1, 1'b1, 1'b1, 8'd13},
        {2'd2, 1'b1, 1'b0, 8'd22},
        {2'd2, 1'b1, 1'b1, 8'd23},
        {2'd3, 1'b1, 1'b0, 8'd32},
        {2'd3, 1'b1, 1'b1, 8'd33},
        {2'd0, 1'b1, 1'b0, 8'd60},
        {2'd3, 1'b0, 1'b0, 8'd60}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic busy = 1'b0;
    logic [1:0] sel = 2'd0;
    logic ie = 1'b1;
    logic gie = 1'b1;
    logic clr = 1'b0;
    logic flag, irq;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    scl_stretch_guard #(.CLK_HZ(1000), .LIM1_CYC(L1), .LIM2_CYC(L2), .LIM3_CYC(L3)) u_dut (
        .clk(clk), .rst(rst), .scl_i(scl), .xfer_busy(busy), .tmo_sel(sel),
        .tmo_ie(ie), .glob_ie(gie), .tmo_clr(clr), .tmo_flag(flag), .tmo_irq(irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        edges(1);
        clr = 1'b0;
    endtask

    initial begin
        edges(3);
        check("R1 flag", flag, 1'b0);
        check("R1 irq", irq, 1'b0);
        rst = 1'b0;
        edges(1);
        check("R1 after", flag, 1'b0);

        // table: R2 R3 R4 R8
        for (int i = 0; i < NV; i++) begin
            sel = VEC[i][11:10];
            busy = VEC[i][9];
            scl = 1'b1;
            edges(4);
            pulse_clr();
            scl = 1'b0;
            edges(int'(VEC[i][7:0]));
            check($sformatf("R3/R2/R4 vec%0d flag", i), flag, VEC[i][8]);
            check($sformatf("R8 vec%0d irq", i), irq, VEC[i][8]);
            scl = 1'b1;
        end

        // R5 and R7: set, clear while still low, no second set
        sel = 2'd1; busy = 1'b1; scl = 1'b1;
        edges(4); pulse_clr();
        scl = 1'b0;
        edges(L1 + 3);
        check("R3 set L1", flag, 1'b1);
        edges(5);
        check("R7 sticky low", flag, 1'b1);
        pulse_clr();
        check("R7 clear", flag, 1'b0);
        edges(4 * L1);
        check("R5 once per low", flag, 1'b0);

        // R6: re-arm after high
        scl = 1'b1;
        edges(3);
        scl = 1'b0;
        edges(L1 + 3);
        check("R6 rearm", flag, 1'b1);

        // R7: sticky through a high level
        scl = 1'b1;
        edges(10);
        check("R7 sticky high", flag, 1'b1);

        // R8: enable gating
        ie = 1'b0; edges(1);
        check("R8 ie off", irq, 1'b0);
        ie = 1'b1; gie = 1'b0; edges(1);
        check("R8 gie off", irq, 1'b0);
        gie = 1'b1; edges(1);
        check("R8 both on", irq, 1'b1);

        // R9: short high restarts the count
        pulse_clr();
        scl = 1'b0;
        edges(8);
        scl = 1'b1;
        edges(1);
        scl = 1'b0;
        edges(L1 + 2);
        check("R9 restart early", flag, 1'b0);
        edges(1);
        check("R9 restart exact", flag, 1'b1);
        scl = 1'b1;

        // R1: reset mid-flag
        rst = 1'b1;
        edges(2);
        check("R1 reset drops flag", flag, 1'b0);
        rst = 1'b0;
        edges(2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule